// File: doc/BRIEF.md
# Serial Word Transmitter with Selectable Parity and Return-to-Zero Rails

This block accepts 32-bit words from a host, queues them in a 32-entry first-in first-out buffer, and sends each one bit-serially on a pair of return-to-zero rails. The rails feed an external line driver. A 1 pulses the high rail and a 0 pulses the low rail, each for the first half of the bit period. Both rails rest low during the second half and between words.

Three controls shape each word, and all three are sampled when the word is taken from the buffer:
- The parity-enable control chooses whether the top bit carries the word's own data or a computed parity bit.
- The parity-invert control chooses odd or even sense for that bit.
- The rate control chooses a bit period of either the fast or the slow clock divisor.

Occupancy flags report the buffer state: empty, full, and half full. Full and half full also come out as active-low copies.

The sequencer has four states:
- `S_IDLE`: rails low. It goes to `S_MARK` whenever the buffer holds a word and takes that word.
- `S_MARK`: the first half of a bit. It goes to `S_SPACE` after a half period.
- `S_SPACE`: the second half, rails low. After a half period it goes back to `S_MARK` for the next bit, or to `S_GAP` after the 32nd bit.
- `S_GAP`: rails low for `GAP_BITS` bit periods, then back to `S_IDLE`.

Top module: `rztx_top`

## Requirements
- R1: The buffer stores up to DEPTH (32) words and sends them in write order. A write while `fifo_full` is 1 is discarded.
- R2: `fifo_empty` is 1 exactly when the buffer holds no word.
- R3: `fifo_full` is 1 when the buffer holds DEPTH words. `full_n` is always its inverse.
- R4: `fifo_half` is 1 when DEPTH/2 (16) or more words are held and 0 when fewer are held. `half_n` is always its inverse.
- R5: With `par_en` = 0, bit 31 is sent exactly as written.
- R6: With `par_en` = 1 and `par_inv` = 0, bit 31 is replaced so that the 32 sent bits contain an odd number of ones.
- R7: With `par_en` = 1 and `par_inv` = 1, bit 31 is replaced so that the 32 sent bits contain an even number of ones.
- R8: Each rail pulse lasts DIV_FAST/2 clocks when `rate_slow` = 0 and DIV_SLOW/2 clocks when `rate_slow` = 1. The defaults are divisors 10 and 80.
- R9: For a 1 bit, `tx_hi` pulses for the first half of the bit period; for a 0 bit, `tx_lo` pulses for the same half. Both rails are low in the second half, and they are never high together.
- R10: Bits go out least-significant first, bit 0 through bit 31.
- R11: Sending starts without any command whenever a word is waiting. Between the end of one word's last bit period and the first pulse of the next word, the rails stay low for at least GAP_BITS (4) bit periods.
- R12: After reset the buffer is empty, `fifo_full` and `fifo_half` are 0, and both rails are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; one word per clock |
| wr_data | input | 32 | Word to queue |
| par_en | input | 1 | 1: top bit replaced by parity |
| par_inv | input | 1 | 0: odd parity, 1: even parity |
| rate_slow | input | 1 | 0: fast divisor, 1: slow divisor |
| tx_hi | output | 1 | Return-to-zero rail pulsed for 1 bits |
| tx_lo | output | 1 | Return-to-zero rail pulsed for 0 bits |
| fifo_empty | output | 1 | Buffer holds no word |
| fifo_full | output | 1 | Buffer holds DEPTH words |
| fifo_half | output | 1 | Buffer holds DEPTH/2 or more words |
| full_n | output | 1 | Inverse of fifo_full |
| half_n | output | 1 | Inverse of fifo_half |

## Verification
The bench keeps DEPTH at 32 and GAP_BITS at 4, but uses divisors 4 and 8, so a pulse lasts 2 or 4 clocks. A full 32-word backlog then drains in a few thousand cycles. That brings the half-full boundary at 15 and 16 held words, the full condition with a discarded extra write, and the order of a 33-word stream all within one short run. Because the two divisors give different pulse widths, one rate cannot pass as the other, and the measured inter-word null is checked against the four-bit-period floor.

// File: rtl/rztx_pkg.sv
package rztx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_MARK  = 2'd1,
        S_SPACE = 2'd2,
        S_GAP   = 2'd3
    } tx_state_e;
endpackage

// File: rtl/rztx_fifo.sv
module rztx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rptr];
endmodule

// File: rtl/rztx_halftick.sv
module rztx_halftick #(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic slow,
    output logic tick
);
    localparam int HF = DIV_FAST / 2;
    localparam int HS = DIV_SLOW / 2;
    localparam int CW = $clog2(HS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim  = slow ? CW'(HS - 1) : CW'(HF - 1);
    assign tick = !clr && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rztx_fsm.sv
module rztx_fsm
    import rztx_pkg::*;
#(
    parameter int W        = 32,
    parameter int GAP_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         have_word,
    input  logic [W-1:0] word_in,
    input  logic         par_en,
    input  logic         par_inv,
    input  logic         rate_slow,
    input  logic         tick,
    output logic         pop,
    output logic         tick_clr,
    output logic         rate_q,
    output logic         tx_hi,
    output logic         tx_lo,
    output tx_state_e    state_o
);
    localparam int BW        = $clog2(W);
    localparam int GAP_TICKS = 2 * GAP_BITS;
    localparam int GW        = $clog2(GAP_TICKS);

    tx_state_e     state, state_nx;
    logic [W-1:0]  shreg;
    logic [BW-1:0] bit_cnt;
    logic [GW-1:0] gap_cnt;
    logic [W-1:0]  load_word;
    logic          last_bit;

    // Parity bit makes the ones count of all W bits odd (inv=0) or even (inv=1)
    always_comb begin
        load_word = word_in;
        if (par_en)
            load_word[W-1] = par_inv ? (^word_in[W-2:0]) : ~(^word_in[W-2:0]);
    end

    assign last_bit = (bit_cnt == BW'(W - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (have_word) state_nx = S_MARK;
            S_MARK:  if (tick)      state_nx = S_SPACE;
            S_SPACE: if (tick)      state_nx = last_bit ? S_GAP : S_MARK;
            S_GAP:   if (tick && gap_cnt == GW'(GAP_TICKS - 1)) state_nx = S_IDLE;
            default:                state_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
            rate_q  <= 1'b0;
        end else begin
            if (pop) begin
                shreg   <= load_word;
                bit_cnt <= '0;
                gap_cnt <= '0;
                rate_q  <= rate_slow;
            end else if (state == S_SPACE && tick && !last_bit) begin
                shreg   <= shreg >> 1;
                bit_cnt <= bit_cnt + 1'b1;
            end else if (state == S_GAP && tick) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        pop      = (state == S_IDLE) && have_word;
        tick_clr = (state == S_IDLE);
        tx_hi    = (state == S_MARK) &&  shreg[0];
        tx_lo    = (state == S_MARK) && !shreg[0];
        state_o  = state;
    end
endmodule

// File: rtl/rztx_top.sv
module rztx_top
    import rztx_pkg::*;
#(
    parameter int DEPTH    = 32,
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        par_en,
    input  logic        par_inv,
    input  logic        rate_slow,
    output logic        tx_hi,
    output logic        tx_lo,
    output logic        fifo_empty,
    output logic        fifo_full,
    output logic        fifo_half,
    output logic        full_n,
    output logic        half_n
);
    localparam int W  = 32;
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [W-1:0]  head;
    logic          push, pop, tick, tick_clr, rate_q;
    tx_state_e     state;

    assign push       = wr_en && !fifo_full;
    assign fifo_empty = (count == '0);
    assign fifo_full  = (count == CW'(DEPTH));
    assign fifo_half  = (count >= CW'(DEPTH / 2));
    assign full_n     = ~fifo_full;
    assign half_n     = ~fifo_half;

    rztx_fifo #(.W(W), .DEPTH(DEPTH)) fifo_u (
        .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data),
        .pop(pop), .dout(head), .count(count)
    );

    rztx_halftick #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) tick_u (
        .clk(clk), .rst_n(rst_n), .clr(tick_clr), .slow(rate_q), .tick(tick)
    );

    rztx_fsm #(.W(W), .GAP_BITS(GAP_BITS)) fsm_u (
        .clk(clk), .rst_n(rst_n), .have_word(!fifo_empty), .word_in(head),
        .par_en(par_en), .par_inv(par_inv), .rate_slow(rate_slow), .tick(tick),
        .pop(pop), .tick_clr(tick_clr), .rate_q(rate_q),
        .tx_hi(tx_hi), .tx_lo(tx_lo), .state_o(state)
    );
endmodule

// File: rtl/rztx_chk.sv
module rztx_chk
    import rztx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       tx_hi,
    input logic                       tx_lo,
    input logic                       fifo_empty,
    input logic                       fifo_full,
    input logic                       fifo_half,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input tx_state_e                  state
);
    // R9
    rails_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_hi && tx_lo));

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    // R4
    full_implies_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> fifo_half);

    // R2
    empty_not_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_half && !fifo_full);

    // R11
    gap_exits_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |=> (state == S_GAP || state == S_IDLE));

    // R9
    space_rails_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MARK && $past(state) == S_SPACE) |-> $past(!tx_hi && !tx_lo));
endmodule

bind rztx_top rztx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .tx_hi(tx_hi), .tx_lo(tx_lo),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_half(fifo_half),
    .count(count), .state(state)
);

// File: tb/rztx_top_tb_top.sv
module rztx_top_tb_top;
    localparam int DEPTH = 32;
    localparam int DF    = 4;
    localparam int DS    = 8;
    localparam int GAPB  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        par_en = 1'b0, par_inv = 1'b0, rate_slow = 1'b0;
    logic        tx_hi, tx_lo, fifo_empty, fifo_full, fifo_half, full_n, half_n;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rztx_top #(.DEPTH(DEPTH), .DIV_FAST(DF), .DIV_SLOW(DS), .GAP_BITS(GAPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .par_en(par_en), .par_inv(par_inv), .rate_slow(rate_slow),
        .tx_hi(tx_hi), .tx_lo(tx_lo), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .fifo_half(fifo_half), .full_n(full_n), .half_n(half_n)
    );

    // Line monitor: rebuilds words from the rails, LSB first
    logic [31:0] rx_mem [128];
    int          rx_n = 0;
    logic [31:0] cur = '0;
    int          bidx = 0;
    logic        prev_act = 1'b0;
    int          mark_w = 0, low_run = 0;
    int          min_w = 1000, max_w = 0, min_gap = 100000;
    logic        first_bit = 1'b0;
    int          both_hi = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_hi && tx_lo) both_hi++;
            if (tx_hi || tx_lo) begin
                if (!prev_act) begin
                    if (bidx == 0) begin
                        first_bit = tx_hi;
                        if (rx_n > 0 && low_run < min_gap) min_gap = low_run;
                    end
                    cur[bidx] = tx_hi;
                    mark_w = 1;
                    if (bidx == 31) begin
                        rx_mem[rx_n % 128] = cur;
                        rx_n++;
                        bidx = 0;
                    end else bidx++;
                end else mark_w++;
                low_run = 0;
            end else begin
                if (prev_act) begin
                    if (mark_w < min_w) min_w = mark_w;
                    if (mark_w > max_w) max_w = mark_w;
                end
                low_run++;
            end
            prev_act = tx_hi || tx_lo;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input bit pe, input bit pi);
        logic [31:0] r = w;
        int ones = 0;
        if (pe) begin
            for (int i = 0; i < 31; i++) ones += w[i];
            // odd total: top bit set when the other 31 hold an even count
            r[31] = pi ? (ones % 2 == 1) : (ones % 2 == 0);
        end
        return r;
    endfunction

    task automatic push_word(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int guard = 0;
        while (rx_n < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic send_one(input logic [31:0] w, input bit pe, input bit pi,
                            input bit sl, input string req);
        int base = rx_n;
        par_en = pe; par_inv = pi; rate_slow = sl;
        min_w = 1000; max_w = 0;
        push_word(w);
        wait_rx(base + 1);
        repeat (4) @(negedge clk);
        chk(rx_n == base + 1, req, rx_n, base + 1);
        chk(rx_mem[base % 128] == expect_word(w, pe, pi), req,
            rx_mem[base % 128], expect_word(w, pe, pi));
    endtask

    task automatic t_reset();
        chk(fifo_empty === 1'b1, "R12 empty", fifo_empty, 1);
        chk(fifo_full === 1'b0 && full_n === 1'b1, "R12 full", fifo_full, 0);
        chk(fifo_half === 1'b0 && half_n === 1'b1, "R12 half", fifo_half, 0);
        chk(tx_hi === 1'b0 && tx_lo === 1'b0, "R12 rails", {tx_hi, tx_lo}, 0);
    endtask

    task automatic t_data_bit();
        send_one(32'hA500_0001, 1'b0, 1'b0, 1'b0, "R5 data top bit");
        send_one(32'h1234_5678, 1'b0, 1'b1, 1'b0, "R5 data top bit clear");
        // R10: bit 0 of 0x...5678 is 0, sent first
        chk(first_bit == 1'b0, "R10 lsb first", first_bit, 0);
        send_one(32'h0000_0003, 1'b0, 1'b0, 1'b0, "R10 lsb word");
        chk(first_bit == 1'b1, "R10 lsb first", first_bit, 1);
    endtask

    task automatic t_parity_odd();
        send_one(32'h0000_0003, 1'b1, 1'b0, 1'b0, "R6 odd parity");
        chk(rx_mem[(rx_n - 1) % 128] == 32'h8000_0003, "R6 odd value",
            rx_mem[(rx_n - 1) % 128], 32'h8000_0003);
        send_one(32'h7FFF_FFFF, 1'b1, 1'b0, 1'b0, "R6 odd parity all ones");
    endtask

    task automatic t_parity_even();
        send_one(32'h8000_0003, 1'b1, 1'b1, 1'b0, "R7 even parity");
        chk(rx_mem[(rx_n - 1) % 128] == 32'h0000_0003, "R7 even value",
            rx_mem[(rx_n - 1) % 128], 32'h0000_0003);
        send_one(32'h0000_0007, 1'b1, 1'b1, 1'b0, "R7 even parity odd count");
    endtask

    task automatic t_rate();
        send_one(32'h5555_AAAA, 1'b0, 1'b0, 1'b1, "R8 slow word");
        chk(min_w == DS / 2 && max_w == DS / 2, "R8 slow pulse", max_w, DS / 2);
        send_one(32'hF0F0_0F0F, 1'b0, 1'b0, 1'b0, "R9 fast word");
        chk(min_w == DF / 2 && max_w == DF / 2, "R8 fast pulse", max_w, DF / 2);
        chk(both_hi == 0, "R9 rails exclusive", both_hi, 0);
    endtask

    task automatic t_fill();
        int base = rx_n;
        par_en = 1'b0; par_inv = 1'b0; rate_slow = 1'b0;
        min_gap = 100000;
        for (int i = 0; i < 16; i++) push_word(32'hC0DE_0000 + i);
        // 16 written, first one already taken: 15 held
        chk(fifo_half == 1'b0 && half_n == 1'b1, "R4 below threshold", fifo_half, 0);
        chk(fifo_empty == 1'b0, "R2 not empty", fifo_empty, 0);
        push_word(32'hC0DE_0010);
        chk(fifo_half == 1'b1 && half_n == 1'b0, "R4 at threshold", fifo_half, 1);
        chk(fifo_full == 1'b0 && full_n == 1'b1, "R3 not full", fifo_full, 0);
        for (int i = 17; i < 33; i++) push_word(32'hC0DE_0000 + i);
        chk(fifo_full == 1'b1 && full_n == 1'b0, "R3 full", fifo_full, 1);
        push_word(32'hDEAD_BEEF);
        chk(fifo_full == 1'b1, "R1 full after extra write", fifo_full, 1);
        wait_rx(base + 33);
        repeat (600) @(negedge clk);
        chk(rx_n == base + 33, "R1 extra write dropped", rx_n - base, 33);
        for (int i = 0; i < 33; i++)
            chk(rx_mem[(base + i) % 128] == 32'hC0DE_0000 + i, "R1 order",
                rx_mem[(base + i) % 128], 32'hC0DE_0000 + i);
        chk(fifo_empty == 1'b1, "R2 empty after drain", fifo_empty, 1);
        chk(min_gap >= GAPB * DF + DF / 2, "R11 inter-word null", min_gap, GAPB * DF + DF / 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_bit();
        t_parity_odd();
        t_parity_even();
        t_rate();
        t_fill();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule